// File: doc/BRIEF.md
# Five-Level Level-Shifted Carrier Gate Generator

This block drives the eight gate signals of a single-phase five-level boost inverter. The inverter has one DC source and one flying capacitor. One free-running up/down counter forms a triangular carrier. Four copies of that carrier, offset vertically into adjacent bands, are compared with a signed reference word. The number of bands the reference lies above selects one of five output levels, from −2 to +2 source voltages. Each level is then turned into a fixed switch pattern. At the zero and ±1 levels that pattern parallels the capacitor with the source so it recharges. At the ±2 levels it stacks the capacitor in series with the source. The design does not drive plain H-bridge legs.

The reference is captured once per carrier period, at the trough, so each switching period works from one stable sample. The reference is a plain level-sampled word with no handshake: the block reads it only in the trough cycle and never stalls its producer, so there is no back-pressure. While reset is held or the enable is low, the carrier parks at its trough and the gates sit in the zero-level pattern. This keeps the capacitor tied across the source. The carrier half-period is derived from the system clock and the target switching rate.

Top module: `lspwm_gate_gen`

## Requirements
- R1: While rst_n is low (asynchronously) or en is sampled low at a rising edge, gate_o becomes 8'h0F (S1–S4 on) and level_o becomes 2. The carrier restarts from 0 counting up on the first enabled edge.
- R2: The carrier counts 0,1,…,PEAK,PEAK−1,…,1,0,1,…, one step per enabled cycle, with PEAK = CLK_HZ/(2·PWM_HZ). One switching period is therefore 2·PEAK cycles.
- R3: ref_in is used only in the cycle where the carrier is 0. That value governs the trough cycle and every cycle up to the next trough. Changes to ref_in at other times have no effect on the outputs.
- R4: Carrier k (k = 0..3) equals (k−2)·PEAK + carrier. The level code is the count of carriers that the held reference strictly exceeds, so codes 0,1,2,3,4 stand for −2,−1,0,+1,+2. The code appears on level_o one rising edge after the carrier value it was compared with.
- R5: A reference at or below −2·PEAK gives code 0 in every cycle. A reference above 2·PEAK gives code 4 in every cycle.
- R6: gate_o bit i drives switch S(i+1), and gate_o updates on the same edge as level_o. The patterns are: code 0 → 8'h68 (S4,S6,S7); code 1 → 8'h2B (S1,S2,S4,S6); code 2 → 8'h0F (S1..S4); code 3 → 8'h17 (S1,S2,S3,S5); code 4 → 8'h94 (S3,S5,S8).
- R7: gate_o[6] and gate_o[7] (S7, S8) are never high together. Either one is high only while level_o is 0 or 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulator run enable; low parks the carrier and forces the zero pattern |
| ref_in | input | REF_W | Signed reference word, sampled at the carrier trough |
| gate_o | output | 8 | Switch gate drives, bit i for S(i+1) |
| level_o | output | 3 | Selected level code, 0..4 for −2..+2 |

## Verification
Level and gate outputs are due one rising edge after the carrier value and held sample they depend on. A reference offered in a trough cycle therefore shows at the next edge and governs the whole period that follows. A low enable shows at the next edge, and reset acts at once. The bench keeps a behavioural carrier, sample-and-hold and band count that advance on every rising edge from the inputs alone. It compares the ports against that model on the following falling edge, and drives new inputs shortly after that falling edge so no input changes near an active edge.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

  localparam int NUM_LEVELS   = 5;
  localparam int NUM_CARRIERS = NUM_LEVELS - 1;
  localparam int NUM_SWITCHES = 8;
  localparam int LVL_W        = $clog2(NUM_LEVELS);

  typedef enum logic [LVL_W-1:0] {
    LVL_NEG2 = 3'd0,
    LVL_NEG1 = 3'd1,
    LVL_ZERO = 3'd2,
    LVL_POS1 = 3'd3,
    LVL_POS2 = 3'd4
  } lvl_t;

  typedef logic [NUM_SWITCHES-1:0] gate_vec_t;

  // bit i of the vector drives switch i+1
  localparam gate_vec_t PAT_NEG2 = 8'b0110_1000;  // S4 S6 S7
  localparam gate_vec_t PAT_NEG1 = 8'b0010_1011;  // S1 S2 S4 S6
  localparam gate_vec_t PAT_ZERO = 8'b0000_1111;  // S1..S4, capacitor across source
  localparam gate_vec_t PAT_POS1 = 8'b0001_0111;  // S1 S2 S3 S5
  localparam gate_vec_t PAT_POS2 = 8'b1001_0100;  // S3 S5 S8

  function automatic gate_vec_t lvl_pattern(lvl_t l);
    gate_vec_t p;
    case (l)
      LVL_NEG2: p = PAT_NEG2;
      LVL_NEG1: p = PAT_NEG1;
      LVL_POS1: p = PAT_POS1;
      LVL_POS2: p = PAT_POS2;
      default:  p = PAT_ZERO;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lspwm_carrier.sv
module lspwm_carrier #(
  parameter int PEAK  = 20,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trough_o
);

  localparam logic [CNT_W-1:0] TURN_HI = CNT_W'(PEAK - 1);
  localparam logic [CNT_W-1:0] TURN_LO = CNT_W'(1);

  logic rising;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      rising <= 1'b1;
    end else if (!en) begin
      cnt_o  <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == TURN_HI) rising <= 1'b0;
    end else begin
      cnt_o <= cnt_o - 1'b1;
      if (cnt_o == TURN_LO) rising <= 1'b1;
    end
  end

  assign trough_o = (cnt_o == '0);

endmodule

// File: rtl/lspwm_band_cmp.sv
module lspwm_band_cmp
  import lspwm_pkg::*;
#(
  parameter int PEAK  = 20,
  parameter int CNT_W = 5,
  parameter int REF_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    trough_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic signed [REF_W-1:0] ref_q_o,
  output lvl_t                    lvl_d_o,
  output logic [LVL_W-1:0]        lvl_q_o
);

  localparam int WIDE   = (REF_W > CNT_W + 3) ? REF_W : CNT_W + 3;
  localparam int CMP_W  = WIDE + 1;
  localparam int MID    = NUM_CARRIERS / 2;

  logic signed [REF_W-1:0] ref_eff;
  logic signed [CMP_W-1:0] ref_x;
  logic signed [CMP_W-1:0] cnt_x;
  logic [NUM_CARRIERS-1:0] above;
  logic [LVL_W-1:0]        n_above;

  // trough cycle already works on the sample being captured
  assign ref_eff = trough_i ? ref_i : ref_q_o;
  assign ref_x   = CMP_W'(ref_eff);
  assign cnt_x   = signed'({{(CMP_W-CNT_W){1'b0}}, cnt_i});

  for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_band
    localparam int OFS = (k - MID) * PEAK;
    logic signed [CMP_W-1:0] thr;
    assign thr      = CMP_W'(OFS) + cnt_x;
    assign above[k] = (ref_x > thr);
  end

  always_comb begin
    n_above = '0;
    for (int i = 0; i < NUM_CARRIERS; i++) begin
      n_above = n_above + LVL_W'(above[i]);
    end
  end

  assign lvl_d_o = en ? lvl_t'(n_above) : LVL_ZERO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q_o <= '0;
      lvl_q_o <= LVL_ZERO;
    end else if (!en) begin
      ref_q_o <= '0;
      lvl_q_o <= LVL_ZERO;
    end else begin
      if (trough_i) ref_q_o <= ref_i;
      lvl_q_o <= lvl_d_o;
    end
  end

endmodule

// File: rtl/lspwm_gate_dec.sv
module lspwm_gate_dec
  import lspwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lvl_t      lvl_i,
  output gate_vec_t gate_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_o <= PAT_ZERO;
    else        gate_o <= lvl_pattern(lvl_i);
  end

endmodule

// File: rtl/lspwm_gate_gen.sv
module lspwm_gate_gen
  import lspwm_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int PWM_HZ = 5_000,
  parameter int REF_W  = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_in,
  output logic [7:0]              gate_o,
  output logic [2:0]              level_o
);

  localparam int PEAK  = CLK_HZ / (2 * PWM_HZ);
  localparam int CNT_W = $clog2(PEAK + 1);

  logic [CNT_W-1:0]        carrier;
  logic                    trough;
  logic signed [REF_W-1:0] ref_hold;
  lvl_t                    lvl_next;
  logic [LVL_W-1:0]        lvl_reg;
  gate_vec_t               gates;

  lspwm_carrier #(.PEAK(PEAK), .CNT_W(CNT_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cnt_o    (carrier),
    .trough_o (trough)
  );

  lspwm_band_cmp #(.PEAK(PEAK), .CNT_W(CNT_W), .REF_W(REF_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cnt_i    (carrier),
    .trough_i (trough),
    .ref_i    (ref_in),
    .ref_q_o  (ref_hold),
    .lvl_d_o  (lvl_next),
    .lvl_q_o  (lvl_reg)
  );

  lspwm_gate_dec u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_next),
    .gate_o (gates)
  );

  assign gate_o  = gates;
  assign level_o = lvl_reg;

endmodule

// File: rtl/lspwm_gate_gen_chk.sv
module lspwm_gate_gen_chk #(
  parameter int PEAK  = 20,
  parameter int CNT_W = 5,
  parameter int REF_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [CNT_W-1:0]        cnt,
  input logic signed [REF_W-1:0] ref_q,
  input logic [2:0]              level_o,
  input logic [7:0]              gate_o
);

  assert_outer_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[6] && gate_o[7]));

  assert_outer_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o[6] || gate_o[7]) |-> (level_o == 3'd0 || level_o == 3'd4));

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_o == 8'h0F && level_o == 3'd2));

  assert_carrier_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en)) |->
      (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

  assert_carrier_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PEAK));

  assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |=> $stable(ref_q));

  assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= 3'd4);

endmodule

bind lspwm_gate_gen lspwm_gate_gen_chk #(.PEAK(PEAK), .CNT_W(CNT_W), .REF_W(REF_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .cnt     (carrier),
  .ref_q   (ref_hold),
  .level_o (level_o),
  .gate_o  (gate_o)
);

// File: tb/tb_lspwm_gate_gen.sv
module tb_lspwm_gate_gen;

  localparam int CLK_HZ = 400;
  localparam int PWM_HZ = 10;
  localparam int REF_W  = 8;
  localparam int PEAK   = CLK_HZ / (2 * PWM_HZ);

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    en = 1'b0;
  logic signed [REF_W-1:0] ref_in = '0;
  logic [7:0]              gate_o;
  logic [2:0]              level_o;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural model state
  int m_cnt = 0;
  int m_up  = 1;
  int m_ref = 0;
  int m_lvl = 2;

  always #2.5ns clk = ~clk;

  lspwm_gate_gen #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .REF_W(REF_W)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ref_in  (ref_in),
    .gate_o  (gate_o),
    .level_o (level_o)
  );

  function automatic logic [7:0] want_gates(int l);
    case (l)
      0:       return 8'h68;
      1:       return 8'h2B;
      3:       return 8'h17;
      4:       return 8'h94;
      default: return 8'h0F;
    endcase
  endfunction

  always @(posedge clk) begin
    int eff;
    if (!rst_n || !en) begin
      m_cnt = 0; m_up = 1; m_ref = 0; m_lvl = 2;
    end else begin
      eff = (m_cnt == 0) ? int'(ref_in) : m_ref;
      if (m_cnt == 0) m_ref = int'(ref_in);
      m_lvl = 0;
      for (int k = 0; k < 4; k++) begin
        if (eff > (k - 2) * PEAK + m_cnt) m_lvl++;
      end
      if (m_up != 0) begin
        m_cnt++;
        if (m_cnt == PEAK) m_up = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_up = 1;
      end
    end
  end

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%0h exp=%0h", req, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tag, int'(level_o), m_lvl);
      check("R6", int'(gate_o), int'(want_gates(m_lvl)));
      check("R7", int'(gate_o[6] && gate_o[7]), 0);
      check("R7", int'((gate_o[6] || gate_o[7]) && level_o != 3'd0 && level_o != 3'd4), 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #1ns;
    end
  endtask

  initial begin
    int s;
    tag = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(4);
    en = 1'b1;

    // R4: slow sweep through every band, holds change mid-period too
    tag = "R4";
    for (int v = -45; v <= 45; v++) begin
      ref_in = REF_W'(v);
      tick(5);
    end

    // R2: fixed references over whole periods
    tag = "R2";
    ref_in = 8'sd10;  tick(4 * PEAK + 3);
    ref_in = -8'sd25; tick(4 * PEAK + 3);

    // R3: reference flips every cycle, only trough values may count
    tag = "R3";
    for (int i = 0; i < 200; i++) begin
      ref_in = (i % 2 == 0) ? 8'sd35 : -8'sd35;
      tick(1);
    end

    // R5: saturation and outer band boundaries
    tag = "R5";
    ref_in = 8'sd127;  tick(2 * PEAK + 5);
    ref_in = -8'sd128; tick(2 * PEAK + 5);
    ref_in = 8'sd40;   tick(2 * PEAK + 5);
    ref_in = -8'sd40;  tick(2 * PEAK + 5);
    ref_in = 8'sd41;   tick(2 * PEAK + 5);

    // R1: enable drop mid-period and a reset pulse
    tag = "R1";
    ref_in = 8'sd30;
    tick(13);
    en = 1'b0; tick(6);
    en = 1'b1; tick(2 * PEAK);
    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(2 * PEAK);

    // R4: pseudo-random references
    tag = "R4";
    s = 7;
    for (int i = 0; i < 400; i++) begin
      s = s * 1664525 + 1013904223;
      ref_in = REF_W'(((s >>> 16) & 127) - 64);
      tick(1 + (i % 4));
    end

    finish_run();
  end

endmodule